// File: doc/BRIEF.md
# Encoded Reference Clock Divider

This block divides its input clock, the reference, by a ratio picked with a 5-bit code. The code is not a binary count. Its upper two bits choose a family and its lower three bits choose a position within that family. The lowest family gives powers of two. The other three families give a base of 5, 6 or 7 scaled by a power of two. In each of those three families, position zero has no ratio and is flagged as illegal. While an illegal code is applied, the block keeps dividing by the last legal ratio it decoded.

Each division period ends with a comparison strobe that is high for exactly one reference cycle. A new ratio is loaded only at that terminal count, so the period in progress always completes at its old length. A 2-bit route select drives a shared test output with one of three sources: the divided square wave, the raw reference, or a constant low. The select is registered, and its register resets to the code that routes the divided wave.

Top module: `ref_ratio_div`

## Requirements
- R1: With code bits [4:3] = 00, position p = bits [2:0] gives a division period of 2^(p+1) reference cycles (2 to 256).
- R2: With code bits [4:3] = g in 1..3 and position p in 1..7, the period is (4+g)·2^(p-1) cycles, i.e. base 5, 6 or 7 doubled per position (max 448).
- R3: A code with bits [4:3] != 00 and bits [2:0] = 000 drives illegal_o high in the same cycle (combinationally), and the divider keeps the last legal ratio; illegal_o is low for every other code.
- R4: cmp_pulse_o is high for exactly one cycle per division period, and it is high in the first cycle after reset is released.
- R5: A change of code takes effect only at the next terminal count; the period in progress keeps its old length.
- R6: With route select 2'b11, mux_o carries the divided wave, high for ceil(N/2) of each N-cycle period (exactly half for even N).
- R7: Route select 2'b10 puts the raw reference on mux_o, and 2'b00 or 2'b01 hold mux_o low; a select change shows on mux_o one clock edge after it is applied.
- R8: The select register resets to 2'b11, so the divided wave is routed out while reset is held, whatever route_sel_i is.
- R9: The held legal ratio resets to 2 (code 00000), so an illegal code applied from reset gives a period of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_code_i | input | 5 | Division ratio code: family in [4:3], position in [2:0] |
| route_sel_i | input | 2 | Output route: 11 divided wave, 10 reference, 0x low |
| cmp_pulse_o | output | 1 | One-cycle comparison strobe at each terminal count |
| mux_o | output | 1 | Routed test output |
| illegal_o | output | 1 | Applied code has no ratio |

## Verification
The strobe is high from reset release. Each reload takes effect at the edge that follows a strobe, so the bench samples on falling edges and counts how many falling edges pass from one strobe to the next. illegal_o is combinational and is checked a moment after the code changes. A change of route select shows one rising edge later, so the bench checks mux_o on both clock phases after that edge. In the sweep the bench waits for one strobe before it measures, because a new code applies only to the period that starts after the pending terminal count.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  localparam int unsigned GRP_W   = 2;
  localparam int unsigned POS_W   = 3;
  localparam int unsigned CODE_W  = GRP_W + POS_W;
  localparam int unsigned RATIO_W = 9;  // holds 448
  localparam int unsigned SHIFT_W = POS_W + 1;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [CODE_W-1:0]  code_t;

  typedef enum logic [1:0] {
    ROUTE_LOW0 = 2'b00,
    ROUTE_LOW1 = 2'b01,
    ROUTE_REF  = 2'b10,
    ROUTE_CMP  = 2'b11
  } route_e;

  localparam ratio_t RESET_RATIO = ratio_t'(2);
endpackage

// File: rtl/ratio_decode.sv
module ratio_decode
  import ref_div_pkg::*;
(
  input  code_t  code_i,
  output ratio_t ratio_o,
  output logic   illegal_o
);
  logic [GRP_W-1:0]   grp;
  logic [POS_W-1:0]   pos;
  logic [SHIFT_W-1:0] sh;

  assign grp = code_i[CODE_W-1:POS_W];
  assign pos = code_i[POS_W-1:0];

  always_comb begin
    illegal_o = (grp != '0) && (pos == '0);
    if (grp == '0) begin
      sh      = {1'b0, pos} + SHIFT_W'(1);
      ratio_o = ratio_t'(1) << sh;
    end else begin
      // base 4+grp is just a leading one above the family bits
      sh      = illegal_o ? '0 : ({1'b0, pos} - SHIFT_W'(1));
      ratio_o = ratio_t'({1'b1, grp}) << sh;
    end
  end
endmodule

// File: rtl/ratio_hold.sv
module ratio_hold
  import ref_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t dec_ratio_i,
  input  logic   illegal_i,
  output ratio_t eff_ratio_o,
  output ratio_t hold_ratio_o
);
  ratio_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= RESET_RATIO;
    else if (!illegal_i) hold_q <= dec_ratio_i;
  end

  assign eff_ratio_o  = illegal_i ? hold_q : dec_ratio_i;
  assign hold_ratio_o = hold_q;
endmodule

// File: rtl/div_counter.sv
module div_counter
  import ref_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t next_ratio_i,
  output logic   tc_o,
  output logic   wave_o,
  output ratio_t act_ratio_o
);
  ratio_t cnt_q, act_q;

  assign tc_o = (cnt_q == '0);

  // reload only at terminal count: no runt periods
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= RESET_RATIO;
    end else if (tc_o) begin
      cnt_q <= next_ratio_i - ratio_t'(1);
      act_q <= next_ratio_i;
    end else begin
      cnt_q <= cnt_q - ratio_t'(1);
    end
  end

  assign wave_o      = (cnt_q >= (act_q >> 1));
  assign act_ratio_o = act_q;
endmodule

// File: rtl/out_route.sv
module out_route
  import ref_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       wave_i,
  output logic       mux_o
);
  route_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= ROUTE_CMP;
    else         sel_q <= route_e'(sel_i);
  end

  always_comb begin
    unique case (sel_q)
      ROUTE_CMP: mux_o = wave_i;
      ROUTE_REF: mux_o = clk_i;
      default:   mux_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ref_ratio_div.sv
module ref_ratio_div
  import ref_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [4:0] ratio_code_i,
  input  logic [1:0] route_sel_i,
  output logic       cmp_pulse_o,
  output logic       mux_o,
  output logic       illegal_o
);
  ratio_t dec_ratio, eff_ratio, hold_ratio, act_ratio;
  logic   wave;

  ratio_decode u_dec (
    .code_i    (code_t'(ratio_code_i)),
    .ratio_o   (dec_ratio),
    .illegal_o (illegal_o)
  );

  ratio_hold u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dec_ratio_i  (dec_ratio),
    .illegal_i    (illegal_o),
    .eff_ratio_o  (eff_ratio),
    .hold_ratio_o (hold_ratio)
  );

  div_counter u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .next_ratio_i (eff_ratio),
    .tc_o         (cmp_pulse_o),
    .wave_o       (wave),
    .act_ratio_o  (act_ratio)
  );

  out_route u_route (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (route_sel_i),
    .wave_i (wave),
    .mux_o  (mux_o)
  );
endmodule

// File: rtl/ref_ratio_div_chk.sv
module ref_ratio_div_chk
  import ref_div_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] ratio_code_i,
  input logic [1:0] route_sel_i,
  input logic       cmp_pulse_o,
  input logic       mux_o,
  input logic       illegal_o,
  input ratio_t     act_ratio,
  input ratio_t     hold_ratio
);
  // R4
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_pulse_o |=> !cmp_pulse_o);

  // R5
  no_runt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_pulse_o |=> $stable(act_ratio));

  // R3
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_pulse_o && illegal_o) |=> (act_ratio == $past(hold_ratio)));

  // R1
  base_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_pulse_o && ratio_code_i == 5'b00000) |=> (act_ratio == ratio_t'(2)));

  // R7
  route_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_sel_i[1] |=> !mux_o);
endmodule

bind ref_ratio_div ref_ratio_div_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ratio_code_i (ratio_code_i),
  .route_sel_i  (route_sel_i),
  .cmp_pulse_o  (cmp_pulse_o),
  .mux_o        (mux_o),
  .illegal_o    (illegal_o),
  .act_ratio    (act_ratio),
  .hold_ratio   (hold_ratio)
);

// File: tb/tb_ref_ratio_div.sv
module tb_ref_ratio_div;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] ratio_code_i = 5'd8;
  logic [1:0] route_sel_i = 2'b10;
  logic       cmp_pulse_o, mux_o, illegal_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  ref_ratio_div dut (
    .clk_i, .rst_ni, .ratio_code_i, .route_sel_i,
    .cmp_pulse_o, .mux_o, .illegal_o
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input int code);
    int g = code / 8;
    int p = code % 8;
    if (g == 0) return 1 << (p + 1);
    return (4 + g) << (p - 1);
  endfunction

  function automatic bit exp_illegal(input int code);
    return (code / 8 != 0) && (code % 8 == 0);
  endfunction

  // count falling edges to next strobe, and high samples of mux_o
  task automatic run_period(output int n, output int hi);
    n = 0; hi = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (mux_o) hi++;
    end while (!cmp_pulse_o && n < 1000);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, hi, legal_ratio;
    // R8: select register held at comparison route during reset
    @(posedge clk_i); #1;
    check("R8 mux during reset", mux_o, 0);
    check("R4 strobe in reset", cmp_pulse_o, 1);
    check("R3 illegal flag code 8", illegal_o, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    route_sel_i = 2'b11;
    #1;
    check("R4 strobe at release", cmp_pulse_o, 1);
    run_period(n, hi);
    check("R9 period from reset hold", n, 2);

    // R1 R2 R3 R6 sweep
    legal_ratio = 2;
    for (int c = 0; c < 32; c++) begin
      int exp_n;
      ratio_code_i = 5'(c);
      #1;
      check(exp_illegal(c) ? "R3 flag" : "R3 flag clear", illegal_o, int'(exp_illegal(c)));
      if (!exp_illegal(c)) legal_ratio = exp_ratio(c);
      exp_n = legal_ratio;
      run_period(n, hi);
      run_period(n, hi);
      check(c < 8 ? "R1 period" : (exp_illegal(c) ? "R3 held period" : "R2 period"), n, exp_n);
      check("R6 wave high count", hi, exp_n - exp_n / 2);
      tests++;
      if (n < 1 || n > 448) begin
        fails++;
        $display("FAIL R4 strobe spacing: actual %0d expected %0d", n, exp_n);
      end
    end

    // R5: mid-period change keeps current period
    ratio_code_i = 5'd3;
    run_period(n, hi);
    run_period(n, hi);
    check("R5 setup 16", n, 16);
    repeat (3) @(negedge clk_i);
    ratio_code_i = 5'd0;
    run_period(n, hi);
    check("R5 no runt", n, 13);
    run_period(n, hi);
    check("R5 new ratio", n, 2);

    // R7: routing
    route_sel_i = 2'b10;
    @(posedge clk_i); #1;
    check("R7 ref high", mux_o, 1);
    @(negedge clk_i); #1;
    check("R7 ref low", mux_o, 0);
    for (int s = 0; s < 2; s++) begin
      int seen = 0;
      route_sel_i = 2'(s);
      @(posedge clk_i);
      for (int k = 0; k < 8; k++) begin
        #(CLK_P/4);
        if (mux_o) seen++;
        #(CLK_P/4);
      end
      check("R7 low route", seen, 0);
    end
    route_sel_i = 2'b11;
    run_period(n, hi);
    run_period(n, hi);
    check("R6 wave back", hi, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule